// File: doc/BRIEF.md
# Interrupt Source Controller for Level and Message Sources

This block holds a table of interrupt sources and turns their input activity into presentation requests for a downstream presenter. Each source is fixed at build time as either level-triggered or message-style (edge). Each source also carries a programmable destination server, a priority and a spare saved priority. A priority of 0xFF masks the source. A small status set per source remembers what happened while it was masked or refused: the live level, whether it has been sent, whether it was refused, and whether an edge arrived while masked. Refused or masked interrupts can then be replayed rather than dropped.

The presenter receives requests on a valid/ready stream, with one request held in an output register at a time. It may refuse a request in the cycle it accepts it, or later through a separate refusal notice. It signals end of service with an EOI. A resend pulse starts a scan that visits every source once, lowest index first, one per cycle. Interrupt numbers on all interfaces are global: the local index plus a base of 0x1000. A combinational query port shows the stored configuration and status of any one source.

Top module: `irq_source_ctrl`

## Requirements
- R1: Reset sets every priority and saved priority to 0xFF, clears every status bit and the output request. Each source keeps its build-time type across reset.
- R2: A rising edge on a message source whose priority is 0xFF sets its masked-pending bit (status bit 3) and issues no request.
- R3: A rising edge on an unmasked message source issues a request carrying number 0x1000+index, the source's server and its priority.
- R4: A level source copies its input into the asserted bit (status bit 0). On a rising level, if unmasked and the sent bit (status bit 1) is clear, it sets sent and issues one request. A held level causes no further request.
- R5: A refusal, either req_reject at the handshake or a rej_valid notice, sets the rejected bit (status bit 2) of a message source and clears the sent bit of a level source.
- R6: During a resend scan, a message source with rejected set clears that bit and issues a request only if unmasked. A level source repeats the R4 check, using its current level.
- R7: A configuration write stores server, priority and saved priority. A message source with masked-pending and a new priority other than 0xFF then clears masked-pending and issues a request. A level source runs the R4 check.
- R8: An EOI clears the sent bit of a level source. It leaves a message source's status unchanged and issues no request.
- R9: Once req_valid is high, it and req_num, req_server and req_prio stay unchanged until req_ready. No request ever carries priority 0xFF.
- R10: Refusal and EOI numbers outside 0x1000 to 0x1000+N-1 change no source, even if their low bits match an index.
- R11: When several sources are waiting, the lowest index is issued first.
- R12: The query port returns the selected source's server, priority, saved priority and status in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Per-source input: an edge for message sources, a level for level sources |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_src | input | IDX_W | Local index to configure |
| cfg_server | input | SRV_W | Destination server |
| cfg_prio | input | 8 | Priority, where 0xFF means masked |
| cfg_saved | input | 8 | Saved priority |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Presenter takes the request |
| req_reject | input | 1 | Presenter refuses the request being taken |
| req_num | output | NUM_W | Global interrupt number |
| req_server | output | SRV_W | Destination server |
| req_prio | output | 8 | Request priority |
| rej_valid | input | 1 | Later refusal notice |
| rej_num | input | NUM_W | Number refused |
| eoi_valid | input | 1 | End-of-service strobe |
| eoi_num | input | NUM_W | Number serviced |
| resend_req | input | 1 | Start (or restart) the replay scan |
| qry_src | input | IDX_W | Index to inspect |
| qry_server | output | SRV_W | Stored server |
| qry_prio | output | 8 | Stored priority |
| qry_saved | output | 8 | Stored saved priority |
| qry_status | output | 4 | {masked-pending, rejected, sent, asserted} |

Back-pressure: the presenter holds req_ready low to stall. Sources keep waiting internally and lose nothing.

## Verification
Message sources are driven with edges while masked, while unmasked, and across refusals and replays. This shows that masked-pending and rejected keep an event alive, and that EOI leaves these sources alone. Level sources are held high across accept, EOI, refusal and replay. This shows that a held level presents once per sent cycle and re-presents only when a check is triggered. Two simultaneous edges with a stalled presenter test ordering and output stability. Aliased out-of-range numbers and a second reset test the decoding and the preserved type.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef logic [7:0] prio_t;
  localparam prio_t PRIO_OFF = 8'hFF;

  typedef struct packed {
    logic mpend;     // bit 3
    logic rejected;  // bit 2
    logic sent;      // bit 1
    logic asserted;  // bit 0
  } src_status_t;
endpackage

// File: rtl/isc_source.sv
module isc_source
  import isc_pkg::*;
#(
  parameter bit IS_LSI = 1'b0,
  parameter int SRV_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_in,
  input  logic             cfg_hit,
  input  logic [SRV_W-1:0] cfg_server,
  input  prio_t            cfg_prio,
  input  prio_t            cfg_saved,
  input  logic             rej_hit,
  input  logic             eoi_hit,
  input  logic             resend_hit,
  input  logic             take,
  output logic             elig,
  output logic [SRV_W-1:0] server,
  output prio_t            prio,
  output prio_t            saved,
  output src_status_t      status
);
  src_status_t      st_q, st_n;
  logic [SRV_W-1:0] srv_q, srv_n;
  prio_t            prio_q, prio_n, saved_q, saved_n;
  logic             want_q, want_n;
  logic             lvl_q;
  logic             rise;

  assign rise = lvl_in & ~lvl_q;

  generate
    if (IS_LSI) begin : g_level
      always_comb begin
        st_n    = st_q;
        srv_n   = srv_q;
        prio_n  = prio_q;
        saved_n = saved_q;
        want_n  = want_q & ~take;
        if (cfg_hit) begin
          srv_n   = cfg_server;
          prio_n  = cfg_prio;
          saved_n = cfg_saved;
        end
        st_n.asserted = lvl_in;
        if (rej_hit || eoi_hit) st_n.sent = 1'b0;
        if ((rise || cfg_hit || resend_hit) && (prio_n != PRIO_OFF) &&
            st_n.asserted && !st_n.sent) begin
          st_n.sent = 1'b1;
          want_n    = 1'b1;
        end
      end
    end else begin : g_message
      always_comb begin
        st_n    = st_q;
        srv_n   = srv_q;
        prio_n  = prio_q;
        saved_n = saved_q;
        want_n  = want_q & ~take;
        if (cfg_hit) begin
          srv_n   = cfg_server;
          prio_n  = cfg_prio;
          saved_n = cfg_saved;
        end
        // end of service carries no state for message sources
        st_n.sent = st_n.sent & ~eoi_hit;
        if (rej_hit) st_n.rejected = 1'b1;
        if (cfg_hit && st_n.mpend && (prio_n != PRIO_OFF)) begin
          st_n.mpend = 1'b0;
          want_n     = 1'b1;
        end
        if (rise) begin
          if (prio_n == PRIO_OFF) st_n.mpend = 1'b1;
          else                    want_n     = 1'b1;
        end
        if (resend_hit && st_n.rejected) begin
          st_n.rejected = 1'b0;
          if (prio_n != PRIO_OFF) want_n = 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= '0;
      srv_q   <= '0;
      prio_q  <= PRIO_OFF;
      saved_q <= PRIO_OFF;
      want_q  <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      srv_q   <= srv_n;
      prio_q  <= prio_n;
      saved_q <= saved_n;
      want_q  <= want_n;
      lvl_q   <= lvl_in;
    end
  end

  assign elig   = want_q && (prio_q != PRIO_OFF);
  assign server = srv_q;
  assign prio   = prio_q;
  assign saved  = saved_q;
  assign status = st_q;
endmodule

// File: rtl/isc_arbiter.sv
module isc_arbiter #(
  parameter int NSRC  = 8,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  elig,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [NSRC-1:0]  onehot
);
  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) idx = IDX_W'(i);
    end
    any    = |elig;
    onehot = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (any && (idx == IDX_W'(i))) onehot[i] = 1'b1;
    end
  end
endmodule

// File: rtl/isc_resend_scan.sv
module isc_resend_scan #(
  parameter int NSRC  = 8,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic [NSRC-1:0] hit
);
  logic             active;
  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == IDX_W'(NSRC - 1)) active <= 1'b0;
      else                         cnt    <= cnt + 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++) hit[i] = active && (cnt == IDX_W'(i));
  end
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
  import isc_pkg::*;
#(
  parameter int              NSRC     = 8,
  parameter int              SRV_W    = 4,
  parameter int              NUM_W    = 24,
  parameter int unsigned     NUM_BASE = 32'h1000,
  parameter logic [NSRC-1:0] LSI_MAP  = {{(NSRC/2){1'b1}}, {(NSRC-NSRC/2){1'b0}}},
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_in,
  input  logic             cfg_valid,
  input  logic [IDX_W-1:0] cfg_src,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [7:0]       cfg_prio,
  input  logic [7:0]       cfg_saved,
  output logic             req_valid,
  input  logic             req_ready,
  input  logic             req_reject,
  output logic [NUM_W-1:0] req_num,
  output logic [SRV_W-1:0] req_server,
  output logic [7:0]       req_prio,
  input  logic             rej_valid,
  input  logic [NUM_W-1:0] rej_num,
  input  logic             eoi_valid,
  input  logic [NUM_W-1:0] eoi_num,
  input  logic             resend_req,
  input  logic [IDX_W-1:0] qry_src,
  output logic [SRV_W-1:0] qry_server,
  output logic [7:0]       qry_prio,
  output logic [7:0]       qry_saved,
  output logic [3:0]       qry_status
);
  logic [NSRC-1:0]             cfg_hit, rej_hit, eoi_hit, resend_hit, take, elig;
  logic [NSRC-1:0][SRV_W-1:0]  srv_all;
  prio_t [NSRC-1:0]            prio_all, saved_all;
  src_status_t [NSRC-1:0]      st_all;

  logic             any;
  logic [IDX_W-1:0] gnt_idx;
  logic [NSRC-1:0]  gnt_onehot;
  logic             load, hs_reject;
  logic [IDX_W-1:0] slot_idx;
  logic [SRV_W-1:0] sel_srv;
  prio_t            sel_prio;

  assign hs_reject = req_valid && req_ready && req_reject;
  assign load      = any && (!req_valid || req_ready);
  assign take      = load ? gnt_onehot : '0;

  isc_resend_scan #(.NSRC(NSRC)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(resend_req), .hit(resend_hit)
  );

  isc_arbiter #(.NSRC(NSRC)) u_arb (
    .elig(elig), .any(any), .idx(gnt_idx), .onehot(gnt_onehot)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign cfg_hit[i] = cfg_valid && (cfg_src == IDX_W'(i));
    assign rej_hit[i] = (rej_valid && (rej_num == NUM_W'(NUM_BASE + i))) ||
                        (hs_reject && (slot_idx == IDX_W'(i)));
    assign eoi_hit[i] = eoi_valid && (eoi_num == NUM_W'(NUM_BASE + i));

    isc_source #(.IS_LSI(LSI_MAP[i]), .SRV_W(SRV_W)) u_src (
      .clk(clk), .rst_n(rst_n), .lvl_in(src_in[i]),
      .cfg_hit(cfg_hit[i]), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
      .cfg_saved(cfg_saved), .rej_hit(rej_hit[i]), .eoi_hit(eoi_hit[i]),
      .resend_hit(resend_hit[i]), .take(take[i]), .elig(elig[i]),
      .server(srv_all[i]), .prio(prio_all[i]), .saved(saved_all[i]),
      .status(st_all[i])
    );
  end

  always_comb begin
    sel_srv  = '0;
    sel_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (gnt_onehot[i]) begin
        sel_srv  = srv_all[i];
        sel_prio = prio_all[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      req_num    <= '0;
      req_server <= '0;
      req_prio   <= '0;
      slot_idx   <= '0;
    end else if (load) begin
      req_valid  <= 1'b1;
      req_num    <= NUM_W'(NUM_BASE) + NUM_W'(gnt_idx);
      req_server <= sel_srv;
      req_prio   <= sel_prio;
      slot_idx   <= gnt_idx;
    end else if (req_ready) begin
      req_valid  <= 1'b0;
    end
  end

  always_comb begin
    qry_server = '0;
    qry_prio   = '0;
    qry_saved  = '0;
    qry_status = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (qry_src == IDX_W'(i)) begin
        qry_server = srv_all[i];
        qry_prio   = prio_all[i];
        qry_saved  = saved_all[i];
        qry_status = st_all[i];
      end
    end
  end
endmodule

// File: rtl/irq_source_ctrl_chk.sv
module irq_source_ctrl_chk
  import isc_pkg::*;
#(
  parameter int              NSRC    = 8,
  parameter int              SRV_W   = 4,
  parameter int              NUM_W   = 24,
  parameter logic [NSRC-1:0] LSI_MAP = '0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [NUM_W-1:0]       req_num,
  input logic [SRV_W-1:0]       req_server,
  input logic [7:0]             req_prio,
  input src_status_t [NSRC-1:0] st_all,
  input prio_t [NSRC-1:0]       prio_all
);
  // R9: an offered request is held unchanged until taken
  a_r9_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_num) &&
      $stable(req_server) && $stable(req_prio));

  // R9: masked priority never reaches the presenter
  a_r9_never_masked: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_prio != PRIO_OFF);

  // R1: first cycle out of reset offers nothing
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !req_valid);

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    if (LSI_MAP[i]) begin : g_lvl
      // R4: sent only becomes set while the level is present
      a_r4_sent_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_all[i].sent) |-> st_all[i].asserted);
    end else begin : g_msg
      // R2: masked-pending only appears on a masked source
      a_r2_pending_only_masked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_all[i].mpend) |-> prio_all[i] == PRIO_OFF);
    end
  end
endmodule

bind irq_source_ctrl irq_source_ctrl_chk #(
  .NSRC(NSRC), .SRV_W(SRV_W), .NUM_W(NUM_W), .LSI_MAP(LSI_MAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_num(req_num), .req_server(req_server), .req_prio(req_prio),
  .st_all(st_all), .prio_all(prio_all)
);

// File: tb/irq_source_ctrl_bench.sv
module irq_source_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  src_in;
  logic        cfg_valid;
  logic [2:0]  cfg_src;
  logic [3:0]  cfg_server;
  logic [7:0]  cfg_prio, cfg_saved;
  logic        req_valid, req_ready, req_reject;
  logic [23:0] req_num;
  logic [3:0]  req_server;
  logic [7:0]  req_prio;
  logic        rej_valid, eoi_valid, resend_req;
  logic [23:0] rej_num, eoi_num;
  logic [2:0]  qry_src;
  logic [3:0]  qry_server;
  logic [7:0]  qry_prio, qry_saved;
  logic [3:0]  qry_status;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_source_ctrl u_irq_source_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .cfg_valid(cfg_valid), .cfg_src(cfg_src), .cfg_server(cfg_server),
    .cfg_prio(cfg_prio), .cfg_saved(cfg_saved),
    .req_valid(req_valid), .req_ready(req_ready), .req_reject(req_reject),
    .req_num(req_num), .req_server(req_server), .req_prio(req_prio),
    .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend_req(resend_req),
    .qry_src(qry_src), .qry_server(qry_server), .qry_prio(qry_prio),
    .qry_saved(qry_saved), .qry_status(qry_status)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input int idx);
    src_in[idx] = 1'b1; tick();
    src_in[idx] = 1'b0; tick();
  endtask

  task automatic cfg_write(input int idx, input logic [3:0] srv,
                           input logic [7:0] pr, input logic [7:0] sv);
    cfg_valid = 1'b1; cfg_src = 3'(idx); cfg_server = srv;
    cfg_prio = pr; cfg_saved = sv;
    tick();
    cfg_valid = 1'b0;
  endtask

  task automatic send_eoi(input logic [23:0] n);
    eoi_valid = 1'b1; eoi_num = n; tick(); eoi_valid = 1'b0;
  endtask

  task automatic send_rej(input logic [23:0] n);
    rej_valid = 1'b1; rej_num = n; tick(); rej_valid = 1'b0;
  endtask

  task automatic do_resend();
    resend_req = 1'b1; tick(); resend_req = 1'b0;
  endtask

  task automatic expect_status(input int idx, input logic [3:0] exp, input string tag);
    qry_src = 3'(idx); #1;
    chk(qry_status == exp, tag, 32'(qry_status), 32'(exp));
  endtask

  task automatic expect_req(input logic [23:0] num, input logic [3:0] srv,
                            input logic [7:0] pr, input bit rj, input string tag);
    int n;
    n = 0;
    while (!req_valid && n < 20) begin tick(); n++; end
    chk(req_valid === 1'b1, {tag, " valid"}, 32'(req_valid), 1);
    chk(req_num == num && req_server == srv && req_prio == pr, {tag, " fields"},
        {req_num[15:0], req_server, 4'h0, req_prio}, {num[15:0], srv, 4'h0, pr});
    req_ready = 1'b1; req_reject = rj; tick();
    req_ready = 1'b0; req_reject = 1'b0;
  endtask

  task automatic expect_none(input int cycles, input string tag);
    bit seen;
    seen = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      tick();
      if (req_valid) seen = 1'b1;
    end
    chk(!seen, tag, 32'(seen), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) begin
      qry_src = 3'(i); #1;
      chk(qry_prio == 8'hFF && qry_saved == 8'hFF && qry_status == 4'h0,
          "R1 reset state / R12 query", {qry_prio, qry_saved, 12'h0, qry_status},
          {8'hFF, 8'hFF, 16'h0});
    end
    chk(req_valid == 1'b0, "R1 no request after reset", 32'(req_valid), 0);
  endtask

  task automatic t_msi_masked_then_cfg();
    pulse(1);
    expect_none(4, "R2 masked edge issues nothing");
    expect_status(1, 4'b1000, "R2 masked-pending set");
    cfg_write(1, 4'd3, 8'd5, 8'd9);
    qry_src = 3'd1; #1;
    chk(qry_server == 4'd3 && qry_prio == 8'd5 && qry_saved == 8'd9,
        "R7 config stored / R12 query", {qry_server, qry_prio, qry_saved},
        {4'd3, 8'd5, 8'd9});
    expect_status(1, 4'b0000, "R7 masked-pending cleared by unmask");
    expect_req(24'h1001, 4'd3, 8'd5, 1'b0, "R7 replay of masked edge");
  endtask

  task automatic t_msi_reject_resend();
    cfg_write(2, 4'd2, 8'd4, 8'd4);
    expect_none(4, "R7 unmask without pending is silent");
    pulse(2);
    expect_req(24'h1002, 4'd2, 8'd4, 1'b1, "R3 unmasked edge presents");
    expect_status(2, 4'b0100, "R5 same-cycle refusal marks message rejected");
    send_eoi(24'h1002);
    expect_status(2, 4'b0100, "R8 EOI ignored by message source");
    expect_none(12, "R8 EOI on message source issues nothing");
    do_resend();
    expect_req(24'h1002, 4'd2, 8'd4, 1'b0, "R6 resend replays rejected message");
    expect_status(2, 4'b0000, "R6 rejected cleared by resend");
  endtask

  task automatic t_lsi_cycle();
    cfg_write(5, 4'd1, 8'd3, 8'd7);
    expect_none(3, "R4 unmasked level source idle while low");
    src_in[5] = 1'b1;
    expect_req(24'h1005, 4'd1, 8'd3, 1'b0, "R4 rising level presents");
    expect_status(5, 4'b0011, "R4 asserted and sent");
    expect_none(6, "R4 held level gives no repeat");
    send_eoi(24'h1005);
    expect_status(5, 4'b0001, "R8 EOI clears sent");
    expect_none(4, "R8 EOI alone does not replay level");
    do_resend();
    expect_req(24'h1005, 4'd1, 8'd3, 1'b1, "R6 resend repeats level check");
    expect_status(5, 4'b0001, "R5 same-cycle refusal clears sent");
    do_resend();
    expect_req(24'h1005, 4'd1, 8'd3, 1'b0, "R6 resend after refusal");
    send_rej(24'h1005);
    expect_status(5, 4'b0001, "R5 refusal notice clears sent");
    src_in[5] = 1'b0; tick();
    do_resend();
    expect_none(14, "R6 resend with level gone is silent");
  endtask

  task automatic t_lsi_cfg_and_range();
    src_in[6] = 1'b1; tick();
    expect_none(3, "R4 masked level issues nothing");
    expect_status(6, 4'b0001, "R4 asserted tracks level while masked");
    cfg_write(6, 4'd6, 8'd2, 8'd2);
    expect_req(24'h1006, 4'd6, 8'd2, 1'b0, "R7 config runs level check");
    src_in[6] = 1'b0; tick();
    expect_status(6, 4'b0010, "R4 asserted follows level low");
    send_eoi(24'h100E);
    send_eoi(24'h0006);
    send_rej(24'h100E);
    expect_status(6, 4'b0010, "R10 out-of-range numbers ignored");
    send_eoi(24'h1006);
    expect_status(6, 4'b0000, "R8 in-range EOI clears sent");
  endtask

  task automatic t_order_and_hold();
    bit held;
    cfg_write(0, 4'd8, 8'd1, 8'd1);
    cfg_write(3, 4'd9, 8'd6, 8'd6);
    src_in[0] = 1'b1; src_in[3] = 1'b1; tick();
    src_in[0] = 1'b0; src_in[3] = 1'b0; tick();
    held = 1'b1;
    for (int k = 0; k < 3; k++) begin
      if (!(req_valid && req_num == 24'h1000 && req_prio == 8'd1)) held = 1'b0;
      tick();
    end
    chk(held, "R9 request held stable under stall / R11 lowest first",
        {req_num[15:0], 8'h0, req_prio}, {16'h1000, 8'h0, 8'd1});
    expect_req(24'h1000, 4'd8, 8'd1, 1'b0, "R11 lowest index first");
    expect_req(24'h1003, 4'd9, 8'd6, 1'b0, "R11 next index follows");
  endtask

  task automatic t_masked_resend();
    pulse(2);
    expect_req(24'h1002, 4'd2, 8'd4, 1'b1, "R3 message presents again");
    cfg_write(2, 4'd2, 8'hFF, 8'd4);
    do_resend();
    expect_none(14, "R6 masked rejected source not replayed");
    expect_status(2, 4'b0000, "R6 rejected cleared even when masked");
  endtask

  task automatic t_reset_keeps_type();
    do_reset();
    expect_status(5, 4'b0000, "R1 status cleared by reset");
    qry_src = 3'd1; #1;
    chk(qry_prio == 8'hFF && qry_saved == 8'hFF, "R1 priorities restored",
        {qry_prio, qry_saved}, {8'hFF, 8'hFF});
    src_in[4] = 1'b1; tick();
    cfg_write(4, 4'd4, 8'd1, 8'd1);
    expect_req(24'h1004, 4'd4, 8'd1, 1'b0, "R1 level type kept across reset");
    src_in[4] = 1'b0; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_in = '0; cfg_valid = 1'b0; cfg_src = '0;
    cfg_server = '0; cfg_prio = '0; cfg_saved = '0;
    req_ready = 1'b0; req_reject = 1'b0; rej_valid = 1'b0; rej_num = '0;
    eoi_valid = 1'b0; eoi_num = '0; resend_req = 1'b0; qry_src = '0;
    @(negedge clk);
    do_reset();
    t_reset();
    t_msi_masked_then_cfg();
    t_msi_reject_resend();
    t_lsi_cycle();
    t_lsi_cfg_and_range();
    t_order_and_hold();
    t_masked_resend();
    t_reset_keeps_type();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule